// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Discriminator

This block watches one tearing-effect line from a display panel. The panel uses that single wire for both its horizontal and its vertical sync. The block tells the two apart by measuring how long each pulse is. Pulse length is counted in ticks of a slower timebase, which is supplied as a one-cycle-wide tick enable. Each measured pulse is compared with two programmed thresholds: a short one for horizontal sync and a long one for vertical sync. The active level of each sync type can be inverted on its own.

After each vertical sync, the classified events drive a line counter. Depending on the selected mode, a match is raised either when the counter reaches a programmed line or on every vertical sync. The match is signalled as a one-cycle low pulse, so an interrupt controller can trigger on the falling edge.

The match also gates a frame transfer. Start requests are counted while they wait. Each match releases exactly one waiting request as a single start pulse. A request made long before the sync is therefore honoured once, and never twice.

Top module: `te_pulse_match`

## Requirements
- R1: After reset, `match_n` is high, `xfer_start` is low and no start request is waiting.
- R2: A pulse's width is the number of tick-enable cycles for which the synchronised line holds its level. Classification is done when that level ends:
  - a run at the vertical sync's active level whose width is at least `cfg_vs_thresh` is a vertical sync;
  - a run at the horizontal sync's active level whose width is at least `cfg_hs_thresh` and less than `cfg_vs_thresh` is a horizontal sync;
  - shorter runs are ignored.
- R3: The active level is high when the matching invert input (`cfg_hs_inv`, `cfg_vs_inv`) is 0 and low when it is 1. A run at the inactive level is never classified.
- R4: With `cfg_mode` = 3, every vertical sync gives one match and horizontal syncs give none.
- R5: With `cfg_mode` = 2:
  - the line count is cleared by a vertical sync and incremented by a horizontal sync;
  - a match occurs on a horizontal sync whose new count equals `cfg_line`, or on a vertical sync when `cfg_line` is 0.
- R6: With `cfg_mode` = 0 or 1, or with `cfg_enable` low, no match is produced.
- R7: Each match drives `match_n` low for exactly one clock cycle.
- R8: A match with a waiting request gives one `xfer_start` pulse, one cycle after `match_n` falls, and uses up that request. A match with nothing waiting gives no `xfer_start`.
- R9: Requests accumulate and each one is released by a separate match. The waiting count saturates at 2^PEND_W-1, and further requests are then dropped.
- R10: Width counting advances only on cycles where `tick_en` is high, so a slower tick stretches the pulse that a threshold corresponds to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Divided timebase, one cycle per tick |
| te_pin | input | 1 | Tearing-effect line from the panel (asynchronous) |
| cfg_enable | input | 1 | Turns the sync logic on |
| cfg_mode | input | 2 | 0/1 off, 2 line match, 3 frame match |
| cfg_hs_inv | input | 1 | Horizontal sync active low when 1 |
| cfg_vs_inv | input | 1 | Vertical sync active low when 1 |
| cfg_hs_thresh | input | CNT_W | Minimum horizontal sync width in ticks |
| cfg_vs_thresh | input | CNT_W | Minimum vertical sync width in ticks |
| cfg_line | input | LINE_W | Target line for mode 2 |
| xfer_req | input | 1 | One-cycle request to start a transfer |
| match_n | output | 1 | Match event, one-cycle low pulse |
| xfer_start | output | 1 | One-cycle transfer start |

## Verification
The assertions check, on every cycle:
- a disabled block emits no sync events;
- a vertical sync always leaves the line count at zero;
- frame mode never matches on a horizontal sync;
- a start only ever follows a match;
- the waiting count never wraps past its ceiling.

Other behaviour only the bench's scenarios can show:
- threshold boundaries, where a width exactly equal to a threshold qualifies and one tick less does not;
- correct line arithmetic for a target line;
- independent polarity handling of the two sync types;
- stretching of widths by a slower tick;
- the exact number of starts released for a given mix of requests and matches.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
   typedef enum logic [1:0] {
      TE_MODE_OFF   = 2'd0,
      TE_MODE_RSVD  = 2'd1,
      TE_MODE_LINE  = 2'd2,
      TE_MODE_FRAME = 2'd3
   } te_mode_e;
endpackage

// File: rtl/te_width_meter.sv
module te_width_meter #(
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             te_pin,
   input  logic             enable,
   input  logic             hs_inv,
   input  logic             vs_inv,
   input  logic [CNT_W-1:0] hs_th,
   input  logic [CNT_W-1:0] vs_th,
   output logic             hs_evt,
   output logic             vs_evt
);
   localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("te_width_meter: SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 12) begin : g_bad_cnt
         $error("te_width_meter: CNT_W must hold a 12-bit threshold");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl, prev_q, edge_seen;
   logic [CNT_W-1:0]       run_q;
   logic                   hs_ok, vs_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], te_pin};
   end

   assign lvl       = sync_q[SYNC_STAGES-1];
   assign edge_seen = (lvl != prev_q);

   // run length of the level that prev_q holds, in ticks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         run_q  <= '0;
      end else begin
         prev_q <= lvl;
         if (edge_seen)
            run_q <= {{(CNT_W-1){1'b0}}, tick_en};
         else if (tick_en && run_q != RUN_MAX)
            run_q <= run_q + 1'b1;
      end
   end

   assign vs_ok = (prev_q != vs_inv) && (run_q >= vs_th);
   assign hs_ok = (prev_q != hs_inv) && (run_q >= hs_th) && (run_q < vs_th);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_evt <= 1'b0;
         vs_evt <= 1'b0;
      end else begin
         hs_evt <= enable && edge_seen && hs_ok;
         vs_evt <= enable && edge_seen && vs_ok;
      end
   end

   AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !(hs_evt || vs_evt)); // R6
   AST_HS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      hs_evt |=> !hs_evt); // R2
   AST_VS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vs_evt |=> !vs_evt); // R2
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
   import te_sync_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic [LINE_W-1:0] line_tgt,
   input  logic              hs_evt,
   input  logic              vs_evt,
   output logic              match_q
);
   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   generate
      if (LINE_W < 1) begin : g_bad_line
         $error("te_line_tracker: LINE_W must be positive");
      end
   endgenerate

   te_mode_e          mode_e;
   logic [LINE_W-1:0] line_q;
   logic [LINE_W:0]   line_nx;
   logic              hit;

   assign mode_e  = te_mode_e'(mode);
   assign line_nx = {1'b0, line_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          line_q <= '0;
      else if (!enable || vs_evt)          line_q <= '0;
      else if (hs_evt && line_q != LINE_MAX) line_q <= line_nx[LINE_W-1:0];
   end

   always_comb begin
      unique case (mode_e)
         TE_MODE_LINE:  hit = (vs_evt && line_tgt == '0) ||
                              (hs_evt && line_nx == {1'b0, line_tgt});
         TE_MODE_FRAME: hit = vs_evt;
         default:       hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= enable && hit;
   end

   AST_VS_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      vs_evt |=> line_q == '0); // R5
   AST_FRAME_IGNORES_HS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == TE_MODE_FRAME && hs_evt && !vs_evt) |=> !match_q); // R4
   AST_MATCH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      match_q |-> $past(hs_evt || vs_evt)); // R6
endmodule

// File: rtl/te_start_gate.sv
module te_start_gate #(
   parameter int PEND_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic match,
   output logic start_q
);
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   generate
      if (PEND_W < 1) begin : g_bad_pend
         $error("te_start_gate: PEND_W must be positive");
      end
   endgenerate

   logic [PEND_W-1:0] pend_q;
   logic              take;

   // a request arriving with the match is served directly
   assign take = match && (pend_q != '0 || req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= take;
         unique case ({req, take})
            2'b10:   if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end

   AST_START_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(match)); // R8
   AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (match && pend_q == '0 && !req) |=> !start_q); // R8
   AST_PEND_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == PEND_MAX && req && !match) |=> pend_q == PEND_MAX); // R9
endmodule

// File: rtl/te_pulse_match.sv
module te_pulse_match #(
   parameter int CNT_W       = 12,
   parameter int LINE_W      = 11,
   parameter int PEND_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              te_pin,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_hs_inv,
   input  logic              cfg_vs_inv,
   input  logic [CNT_W-1:0]  cfg_hs_thresh,
   input  logic [CNT_W-1:0]  cfg_vs_thresh,
   input  logic [LINE_W-1:0] cfg_line,
   input  logic              xfer_req,
   output logic              match_n,
   output logic              xfer_start
);
   logic hs_evt, vs_evt, match_q;

   te_width_meter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_meter (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .te_pin(te_pin),
      .enable(cfg_enable), .hs_inv(cfg_hs_inv), .vs_inv(cfg_vs_inv),
      .hs_th(cfg_hs_thresh), .vs_th(cfg_vs_thresh),
      .hs_evt(hs_evt), .vs_evt(vs_evt)
   );

   te_line_tracker #(.LINE_W(LINE_W)) u_lines (
      .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .mode(cfg_mode),
      .line_tgt(cfg_line), .hs_evt(hs_evt), .vs_evt(vs_evt),
      .match_q(match_q)
   );

   te_start_gate #(.PEND_W(PEND_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .req(xfer_req), .match(match_q),
      .start_q(xfer_start)
   );

   assign match_n = ~match_q;

   AST_START_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(!match_n)); // R8
endmodule

// File: tb/te_pulse_match_tb.sv
module te_pulse_match_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        half_rate = 1'b0;
   logic        te_pin = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [1:0]  cfg_mode = 2'd3;
   logic        cfg_hs_inv = 1'b0;
   logic        cfg_vs_inv = 1'b0;
   logic [11:0] cfg_hs_thresh = 12'd4;
   logic [11:0] cfg_vs_thresh = 12'd16;
   logic [10:0] cfg_line = '0;
   logic        xfer_req = 1'b0;
   logic        match_n, xfer_start;

   int checks = 0, errors = 0;
   int n_match = 0, n_start = 0, run_low = 0, max_low = 0;

   always #5 clk = ~clk;

   te_pulse_match #(.PEND_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .te_pin(te_pin),
      .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
      .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
      .cfg_hs_thresh(cfg_hs_thresh), .cfg_vs_thresh(cfg_vs_thresh),
      .cfg_line(cfg_line), .xfer_req(xfer_req),
      .match_n(match_n), .xfer_start(xfer_start)
   );

   always @(negedge clk) tick_en <= half_rate ? ~tick_en : 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!match_n) begin
            n_match++;
            run_low++;
            if (run_low > max_low) max_low = run_low;
         end else begin
            run_low = 0;
         end
         if (xfer_start) n_start++;
      end
   end

   // mode[26:25] line[24:14] width[13:2] expected matches[1:0]
   localparam logic [26:0] VEC [0:15] = '{
      {2'd3, 11'd0, 12'd20, 2'd1},  // R4 vertical
      {2'd3, 11'd0, 12'd6,  2'd0},  // R4 horizontal gives none
      {2'd3, 11'd0, 12'd2,  2'd0},  // R2 glitch
      {2'd3, 11'd0, 12'd16, 2'd1},  // R2 exactly vs threshold
      {2'd3, 11'd0, 12'd15, 2'd0},  // R2 one below vs threshold
      {2'd2, 11'd2, 12'd20, 2'd0},  // R5 vs clears, target 2
      {2'd2, 11'd2, 12'd4,  2'd0},  // R5 line 1, exact hs threshold
      {2'd2, 11'd2, 12'd3,  2'd0},  // R2 glitch not counted
      {2'd2, 11'd2, 12'd5,  2'd1},  // R5 line 2 matches
      {2'd2, 11'd2, 12'd5,  2'd0},  // R5 line 3
      {2'd2, 11'd2, 12'd18, 2'd0},  // R5 vs clears
      {2'd2, 11'd2, 12'd6,  2'd0},  // R5 line 1
      {2'd2, 11'd2, 12'd6,  2'd1},  // R5 line 2 matches
      {2'd0, 11'd0, 12'd20, 2'd0},  // R6 mode off
      {2'd0, 11'd0, 12'd6,  2'd0},  // R6 mode off
      {2'd1, 11'd0, 12'd20, 2'd0}   // R6 reserved mode
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic level, input int width);
      @(negedge clk) te_pin = level;
      repeat (width) @(negedge clk);
      te_pin = ~level;
      repeat (12) @(negedge clk);
   endtask

   task automatic match_delta(input logic level, input int width,
                              input int exp, input string tag);
      int base;
      base = n_match;
      pulse(level, width);
      chk((n_match - base) == exp, tag, n_match - base, exp);
   endtask

   task automatic request(input int count);
      for (int k = 0; k < count; k++) begin
         @(negedge clk) xfer_req = 1'b1;
         @(negedge clk) xfer_req = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int base_s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(match_n === 1'b1, "R1 match_n after reset", match_n, 1);
      chk(xfer_start === 1'b0, "R1 xfer_start after reset", xfer_start, 0);
      cfg_enable = 1'b1;
      repeat (4) @(negedge clk);

      // R1 / R8: a match with nothing waiting starts nothing
      base_s = n_start;
      pulse(1'b1, 20);
      chk(n_start == base_s, "R1 R8 no start when empty", n_start - base_s, 0);

      for (int i = 0; i < 16; i++) begin
         int base;
         string tag;
         cfg_mode = VEC[i][26:25];
         cfg_line = VEC[i][24:14];
         tag = (VEC[i][26:25] == 2'd3) ? "R4 vector" :
               (VEC[i][26:25] == 2'd2) ? "R5 vector" : "R6 vector";
         base = n_match;
         pulse(1'b1, int'(VEC[i][13:2]));
         chk((n_match - base) == int'(VEC[i][1:0]), tag,
             n_match - base, int'(VEC[i][1:0]));
      end

      // R5: target line 0 matches on the vertical sync itself
      cfg_mode = 2'd2;
      cfg_line = 11'd0;
      match_delta(1'b1, 20, 1, "R5 target 0 on vs");

      // R6: enable low blocks matches
      cfg_mode = 2'd3;
      cfg_enable = 1'b0;
      match_delta(1'b1, 20, 0, "R6 enable low");
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);

      // R3: both syncs active low, idle high
      cfg_enable = 1'b0;
      @(negedge clk) te_pin = 1'b1;
      repeat (6) @(negedge clk);
      cfg_hs_inv = 1'b1;
      cfg_vs_inv = 1'b1;
      cfg_enable = 1'b1;
      repeat (4) @(negedge clk);
      match_delta(1'b0, 20, 1, "R3 inverted vs low pulse");
      repeat (30) @(negedge clk);
      match_delta(1'b0, 2, 0, "R3 inverted high run ignored");

      // R3: hs active low, vs active high, line match on line 1
      cfg_enable = 1'b0;
      cfg_hs_inv = 1'b1;
      cfg_vs_inv = 1'b0;
      cfg_mode = 2'd2;
      cfg_line = 11'd1;
      repeat (4) @(negedge clk);
      cfg_enable = 1'b1;
      repeat (20) @(negedge clk);
      match_delta(1'b0, 6, 1, "R3 mixed polarity line 1");

      cfg_enable = 1'b0;
      @(negedge clk) te_pin = 1'b0;
      repeat (6) @(negedge clk);
      cfg_hs_inv = 1'b0;
      cfg_vs_inv = 1'b0;
      cfg_mode = 2'd3;
      cfg_enable = 1'b1;
      repeat (4) @(negedge clk);

      // R10: half-rate tick halves the measured width
      half_rate = 1'b1;
      match_delta(1'b1, 20, 0, "R10 20 cycles is 10 ticks");
      match_delta(1'b1, 40, 1, "R10 40 cycles is 20 ticks");
      half_rate = 1'b0;
      repeat (4) @(negedge clk);

      // R8: one request, one start; second match starts nothing
      request(1);
      base_s = n_start;
      pulse(1'b1, 20);
      chk(n_start - base_s == 1, "R8 one start per request", n_start - base_s, 1);
      base_s = n_start;
      pulse(1'b1, 20);
      chk(n_start - base_s == 0, "R8 request used once", n_start - base_s, 0);

      // R9: three waiting requests, four matches
      request(3);
      base_s = n_start;
      for (int k = 0; k < 4; k++) pulse(1'b1, 20);
      chk(n_start - base_s == 3, "R9 three requests released", n_start - base_s, 3);

      // R9: five requests saturate at 3 with PEND_W=2
      request(5);
      base_s = n_start;
      for (int k = 0; k < 5; k++) pulse(1'b1, 20);
      chk(n_start - base_s == 3, "R9 waiting count saturates", n_start - base_s, 3);

      // R7: every match low pulse lasted one cycle
      chk(max_low == 1, "R7 match_n low width", max_low, 1);
      chk(match_n === 1'b1, "R7 match_n idle high", match_n, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule